// File: doc/BRIEF.md
# Carry-Aware Integer Add/Subtract Unit

This block is the integer add/subtract datapath of a processor execute stage. In one cycle it takes two register operands, a 16-bit immediate, the next-instruction address, the stored carry and overflow flags, and an operation code. One cycle later it presents the 64-bit result, the carry-out, the signed-overflow bit and a three-bit compare summary. Every operation is reduced to a single addition `x + y + cin`. Subtraction is always of the "subtract-from" kind: the first operand is inverted and the second is added to it.

The block does not decode instructions, read the register file or hold the flag registers. It only produces the values and the write strobes for them. Two enables choose whether the overflow bit and the compare summary are to be written. The stage that owns the flags uses `ov_wr` and `cmp_wr` to decide what to update.

Top module: `carry_addsub_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero after that edge.
- R2: An operation presented with `in_valid` high at a clock edge has its results on the outputs right after that edge. `out_valid` repeats `in_valid` with one cycle of delay, and `result` holds its value while `out_valid` is low.
- R3: The op codes are 0 add (A+B), 1 subtract-from (~A+B+1) and 8 negate (~A+0+1). Negating the most negative value returns that same value.
- R4: The extended op codes take the carry flag `ca_in` as carry-in: 2 (A+B), 3 (~A+B), 4 (A+all-ones), 5 (~A+all-ones), 6 (A+0) and 7 (~A+0).
- R5: Op 9 adds the sign-extended immediate to A. Op 10 adds the immediate placed in bits 31:16 with zeros below it, sign-extended from bit 31. Op 11 computes ~A + sign-extended immediate + 1.
- R6: For ops 9 and 10, `ra_is_zero` high replaces A with zero. For every other op `ra_is_zero` has no effect on the outputs.
- R7: Op 12 returns `nia` plus the shifted, sign-extended immediate used by op 10.
- R8: Op 13 computes A+B plus a carry-in of `ov_in` when `alt_mode` is 0 and `ca_in` when `alt_mode` is 1.
- R9: `ca_out` is bit 64 of the unsigned 65-bit sum x + y + cin.
- R10: Overflow is set when x and y have the same sign and the sign of the result differs from it. When `ov_en` is low, `ov_out` and `ov_wr` are both 0.
- R11: The compare summary `cmp_out` is {lt, gt, eq} (bit 2 lt, bit 1 gt, bit 0 eq) and is taken from the signed result. Exactly one bit is set when `cmp_en` is high. When `cmp_en` is low, `cmp_out` and `cmp_wr` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code (see R3 to R8) |
| ra_is_zero | input | 1 | First-operand register index is zero |
| opa | input | 64 | First operand A |
| opb | input | 64 | Second operand B |
| imm | input | 16 | Signed immediate |
| nia | input | 64 | Next instruction address |
| ca_in | input | 1 | Stored carry flag |
| ov_in | input | 1 | Stored overflow flag |
| alt_mode | input | 1 | Carry-in select for op 13 |
| ov_en | input | 1 | Record overflow |
| cmp_en | input | 1 | Record compare summary |
| out_valid | output | 1 | Results valid |
| result | output | 64 | Sum |
| ca_out | output | 1 | Carry-out |
| ov_out | output | 1 | Signed overflow (0 if not enabled) |
| ov_wr | output | 1 | Overflow write strobe |
| cmp_out | output | 3 | {lt, gt, eq} summary (0 if not enabled) |
| cmp_wr | output | 1 | Compare write strobe |

## Verification
The hardest corners to reach are those where the inverted operand meets a carry-in. These are negation of the most negative value, which must overflow and return its own input, and negation of zero, which must carry out and not overflow. Both are reached directly by fixing A and choosing op 8. The same approach is used for the subtract-from forms, with A and B picked so that the carry-out falls on each side. The carry-in source of op 13 is checked by driving `ca_in` and `ov_in` to opposite values for each setting of `alt_mode`, so that picking the wrong flag changes the sum.

// File: rtl/carry_addsub_pkg.sv
`timescale 1ns/1ps
package carry_addsub_pkg;
  typedef enum logic [3:0] {
    OP_ADD     = 4'd0,
    OP_SUBF    = 4'd1,
    OP_ADDE    = 4'd2,
    OP_SUBFE   = 4'd3,
    OP_ADDME   = 4'd4,
    OP_SUBFME  = 4'd5,
    OP_ADDZE   = 4'd6,
    OP_SUBFZE  = 4'd7,
    OP_NEG     = 4'd8,
    OP_ADDI    = 4'd9,
    OP_ADDIS   = 4'd10,
    OP_SUBFIC  = 4'd11,
    OP_ADDPCIS = 4'd12,
    OP_ADDEX   = 4'd13
  } op_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } cmp_t;
endpackage

// File: rtl/addsub_opnd_sel.sv
`timescale 1ns/1ps
module addsub_opnd_sel
  import carry_addsub_pkg::*;
#(
  parameter int W     = 64,
  parameter int IMM_W = 16
) (
  input  op_e              op,
  input  logic             ra_is_zero,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  input  logic [IMM_W-1:0] imm,
  input  logic [W-1:0]     nia,
  input  logic             ca_in,
  input  logic             ov_in,
  input  logic             alt_mode,
  output logic [W-1:0]     x,
  output logic [W-1:0]     y,
  output logic             cin
);
  localparam int LO_PAD = W - IMM_W;
  localparam int HI_PAD = W - 2 * IMM_W;

  logic [W-1:0] imm_lo;
  logic [W-1:0] imm_hi;
  logic [W-1:0] base;

  assign imm_lo = {{LO_PAD{imm[IMM_W-1]}}, imm};
  assign imm_hi = {{HI_PAD{imm[IMM_W-1]}}, imm, {IMM_W{1'b0}}};
  assign base   = ra_is_zero ? '0 : opa;

  always_comb begin
    x   = opa;
    y   = opb;
    cin = 1'b0;
    case (op)
      OP_SUBF:    begin x = ~opa; cin = 1'b1; end
      OP_ADDE:    cin = ca_in;
      OP_SUBFE:   begin x = ~opa; cin = ca_in; end
      OP_ADDME:   begin y = '1; cin = ca_in; end
      OP_SUBFME:  begin x = ~opa; y = '1; cin = ca_in; end
      OP_ADDZE:   begin y = '0; cin = ca_in; end
      OP_SUBFZE:  begin x = ~opa; y = '0; cin = ca_in; end
      OP_NEG:     begin x = ~opa; y = '0; cin = 1'b1; end
      OP_ADDI:    begin x = base; y = imm_lo; end
      OP_ADDIS:   begin x = base; y = imm_hi; end
      OP_SUBFIC:  begin x = ~opa; y = imm_lo; cin = 1'b1; end
      OP_ADDPCIS: begin x = nia; y = imm_hi; end
      OP_ADDEX:   cin = alt_mode ? ca_in : ov_in;
      default:    ;
    endcase
  end
endmodule

// File: rtl/addsub_core.sv
`timescale 1ns/1ps
module addsub_core #(
  parameter int W = 64
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] wide;

  assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign sum  = wide[W-1:0];
  assign cout = wide[W];
  assign ovf  = (x[W-1] == y[W-1]) && (wide[W-1] != x[W-1]);
endmodule

// File: rtl/addsub_cmp.sv
`timescale 1ns/1ps
module addsub_cmp
  import carry_addsub_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] value,
  output cmp_t         summary
);
  always_comb begin
    summary.lt = value[W-1];
    summary.eq = (value == '0);
    summary.gt = !summary.lt && !summary.eq;
  end
endmodule

// File: rtl/carry_addsub_unit.sv
`timescale 1ns/1ps
module carry_addsub_unit
  import carry_addsub_pkg::*;
#(
  parameter int W     = 64,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [3:0]       op,
  input  logic             ra_is_zero,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  input  logic [IMM_W-1:0] imm,
  input  logic [W-1:0]     nia,
  input  logic             ca_in,
  input  logic             ov_in,
  input  logic             alt_mode,
  input  logic             ov_en,
  input  logic             cmp_en,
  output logic             out_valid,
  output logic [W-1:0]     result,
  output logic             ca_out,
  output logic             ov_out,
  output logic             ov_wr,
  output logic [2:0]       cmp_out,
  output logic             cmp_wr
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  op_e          op_q;
  logic [W-1:0] x, y, sum;
  logic         cin, cout, ovf;
  cmp_t         summary;

  assign op_q = op_e'(op);

  addsub_opnd_sel #(.W(W), .IMM_W(IMM_W)) u_sel (
    .op(op_q), .ra_is_zero(ra_is_zero), .opa(opa), .opb(opb), .imm(imm),
    .nia(nia), .ca_in(ca_in), .ov_in(ov_in), .alt_mode(alt_mode),
    .x(x), .y(y), .cin(cin)
  );

  addsub_core #(.W(W)) u_core (
    .x(x), .y(y), .cin(cin), .sum(sum), .cout(cout), .ovf(ovf)
  );

  addsub_cmp #(.W(W)) u_cmp (
    .value(sum), .summary(summary)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ca_out    <= 1'b0;
      ov_out    <= 1'b0;
      ov_wr     <= 1'b0;
      cmp_out   <= '0;
      cmp_wr    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      ov_wr     <= in_valid && ov_en;
      cmp_wr    <= in_valid && cmp_en;
      if (in_valid) begin
        result  <= sum;
        ca_out  <= cout;
        ov_out  <= ov_en && ovf;
        cmp_out <= cmp_en ? summary : 3'b000;
      end
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_result_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ov_en) |=> (!ov_out && !ov_wr));

  p_neg_min_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_NEG && ov_en && opa == MOST_NEG)
      |=> (ov_out && result == MOST_NEG));

  p_cmp_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |-> $countones(cmp_out) == 1);

  p_cmp_zero_r11: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |-> (cmp_out[0] == (result == '0)));

  p_ra_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_ADDI && ra_is_zero)
      |=> result == {{(W-IMM_W){$past(imm[IMM_W-1])}}, $past(imm)});
endmodule

// File: tb/carry_addsub_unit_tb.sv
`timescale 1ns/1ps
module carry_addsub_unit_tb;
  localparam int W = 64;
  localparam logic [W-1:0] MNEG = 64'h8000_0000_0000_0000;

  logic clk = 1'b0;
  logic rst, in_valid, ra_is_zero, ca_in, ov_in, alt_mode, ov_en, cmp_en;
  logic [3:0] op;
  logic [W-1:0] opa, opb, nia;
  logic [15:0] imm;
  logic out_valid, ca_out, ov_out, ov_wr, cmp_wr;
  logic [W-1:0] result;
  logic [2:0] cmp_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  carry_addsub_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .ra_is_zero(ra_is_zero),
    .opa(opa), .opb(opb), .imm(imm), .nia(nia), .ca_in(ca_in), .ov_in(ov_in),
    .alt_mode(alt_mode), .ov_en(ov_en), .cmp_en(cmp_en), .out_valid(out_valid),
    .result(result), .ca_out(ca_out), .ov_out(ov_out), .ov_wr(ov_wr),
    .cmp_out(cmp_out), .cmp_wr(cmp_wr)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected {ovf, cout, sum} from the requirement formulas
  function automatic logic [W+1:0] model(input logic [3:0] o, input logic [W-1:0] a,
      input logic [W-1:0] b, input logic [15:0] im, input logic [W-1:0] pc,
      input logic rz, input logic ca, input logic ov, input logic md);
    logic [W-1:0] x, y, slo, shi;
    logic c;
    logic [W:0] s;
    slo = {{48{im[15]}}, im};
    shi = {{32{im[15]}}, im, 16'h0};
    x = a; y = b; c = 1'b0;
    case (o)
      4'd1:  begin x = ~a; c = 1'b1; end
      4'd2:  c = ca;
      4'd3:  begin x = ~a; c = ca; end
      4'd4:  begin y = '1; c = ca; end
      4'd5:  begin x = ~a; y = '1; c = ca; end
      4'd6:  begin y = '0; c = ca; end
      4'd7:  begin x = ~a; y = '0; c = ca; end
      4'd8:  begin x = ~a; y = '0; c = 1'b1; end
      4'd9:  begin x = rz ? '0 : a; y = slo; end
      4'd10: begin x = rz ? '0 : a; y = shi; end
      4'd11: begin x = ~a; y = slo; c = 1'b1; end
      4'd12: begin x = pc; y = shi; end
      4'd13: c = md ? ca : ov;
      default: ;
    endcase
    s = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    model = {(x[W-1] == y[W-1]) && (s[W-1] != x[W-1]), s};
  endfunction

  task automatic run_op(input string req, input logic [3:0] o, input logic [W-1:0] a,
      input logic [W-1:0] b, input logic [15:0] im, input logic rz, input logic ca,
      input logic ov, input logic md, input logic oe, input logic ce);
    logic [W+1:0] m;
    logic [2:0] cx;
    @(negedge clk);
    in_valid = 1'b1; op = o; opa = a; opb = b; imm = im; ra_is_zero = rz;
    ca_in = ca; ov_in = ov; alt_mode = md; ov_en = oe; cmp_en = ce;
    m = model(o, a, b, im, nia, rz, ca, ov, md);
    @(posedge clk); #2;
    in_valid = 1'b0;
    cx = m[W-1] ? 3'b100 : (m[W-1:0] == '0) ? 3'b001 : 3'b010;
    chk({req, " result"}, result, m[W-1:0]);
    chk({req, " valid R2"}, {63'h0, out_valid}, 64'd1);
    chk({req, " carry R9"}, {63'h0, ca_out}, {63'h0, m[W]});
    chk({req, " ovf R10"}, {63'h0, ov_out}, {63'h0, oe & m[W+1]});
    chk({req, " ov_wr R10"}, {63'h0, ov_wr}, {63'h0, oe});
    chk({req, " cmp R11"}, {61'h0, cmp_out}, {61'h0, ce ? cx : 3'b000});
    chk({req, " cmp_wr R11"}, {63'h0, cmp_wr}, {63'h0, ce});
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 valid", {63'h0, out_valid}, 64'd0);
    chk("R1 result", result, 64'd0);
    chk("R1 flags", {59'h0, ca_out, ov_out, ov_wr, cmp_wr, cmp_out[0]}, 64'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_basic;
    run_op("R3 add", 4'd0, 64'd5, 64'd7, 16'h0, 0, 0, 0, 0, 1, 1);
    chk("R3 add literal", result, 64'd12);
    run_op("R3 subf pos", 4'd1, 64'd3, 64'd10, 16'h0, 0, 0, 0, 0, 1, 1);
    chk("R3 subf literal", result, 64'd7);
    chk("R9 subf carry", {63'h0, ca_out}, 64'd1);
    run_op("R3 subf neg", 4'd1, 64'd10, 64'd3, 16'h0, 0, 1, 0, 0, 1, 1);
    run_op("R3 neg", 4'd8, 64'd5, 64'd99, 16'h0, 0, 0, 0, 0, 1, 1);
    chk("R3 neg literal", result, -64'sd5);
    run_op("R3 neg zero", 4'd8, 64'd0, 64'd0, 16'h0, 0, 0, 0, 0, 1, 1);
    chk("R9 neg zero carry", {63'h0, ca_out}, 64'd1);
  endtask

  task automatic t_extended;
    for (int c = 0; c < 2; c++) begin
      run_op("R4 adde", 4'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'h0, 0, c[0], 0, 0, 1, 1);
      run_op("R4 subfe", 4'd3, 64'd4, 64'd9, 16'h0, 0, c[0], 0, 0, 1, 1);
      run_op("R4 addme", 4'd4, 64'd0, 64'd1, 16'h0, 0, c[0], 0, 0, 1, 1);
      run_op("R4 subfme", 4'd5, 64'd7, 64'd1, 16'h0, 0, c[0], 0, 0, 1, 1);
      run_op("R4 addze", 4'd6, 64'h7FFF_FFFF_FFFF_FFFF, 64'd3, 16'h0, 0, c[0], 0, 0, 1, 1);
      run_op("R4 subfze", 4'd7, 64'd0, 64'd3, 16'h0, 0, c[0], 0, 0, 1, 1);
    end
  endtask

  task automatic t_immediate;
    run_op("R5 addi neg", 4'd9, 64'd100, 64'd0, 16'hFFF0, 0, 0, 0, 0, 1, 1);
    chk("R5 addi literal", result, 64'd84);
    run_op("R5 addis", 4'd10, 64'd1, 64'd0, 16'h8001, 0, 0, 0, 0, 1, 1);
    chk("R5 addis literal", result, 64'hFFFF_FFFF_8001_0001);
    run_op("R5 subfic", 4'd11, 64'd20, 64'd0, 16'h0005, 0, 0, 0, 0, 1, 1);
  endtask

  task automatic t_rzero;
    run_op("R6 addi rz", 4'd9, 64'd1000, 64'd0, 16'h0042, 1, 0, 0, 0, 1, 1);
    chk("R6 addi rz literal", result, 64'h42);
    run_op("R6 addis rz", 4'd10, 64'd1000, 64'd0, 16'h0003, 1, 0, 0, 0, 1, 1);
    chk("R6 addis rz literal", result, 64'h3_0000);
    run_op("R6 add ignores rz", 4'd0, 64'd1000, 64'd1, 16'h0, 1, 0, 0, 0, 1, 1);
    chk("R6 add ignores rz literal", result, 64'd1001);
  endtask

  task automatic t_pcis;
    nia = 64'h0000_0000_1000_0004;
    run_op("R7 addpcis", 4'd12, 64'd77, 64'd0, 16'hFFFF, 0, 0, 0, 0, 1, 1);
    chk("R7 addpcis literal", result, 64'h0000_0000_0FFF_0004);
    nia = '0;
  endtask

  task automatic t_altcarry;
    run_op("R8 addex ov", 4'd13, 64'd10, 64'd20, 16'h0, 0, 0, 1, 0, 1, 1);
    chk("R8 addex ov literal", result, 64'd31);
    run_op("R8 addex ca", 4'd13, 64'd10, 64'd20, 16'h0, 0, 0, 1, 1, 1, 1);
    chk("R8 addex ca literal", result, 64'd30);
  endtask

  task automatic t_overflow;
    run_op("R10 add ovf", 4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 0, 0, 0, 0, 1, 1);
    chk("R10 add ovf literal", {63'h0, ov_out}, 64'd1);
    run_op("R3 neg min", 4'd8, MNEG, 64'd0, 16'h0, 0, 0, 0, 0, 1, 1);
    chk("R3 neg min value", result, MNEG);
    chk("R10 neg min ovf", {63'h0, ov_out}, 64'd1);
  endtask

  task automatic t_enables;
    run_op("R10 ov disabled", 4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 0, 0, 0, 0, 0, 1);
    run_op("R11 cmp disabled", 4'd1, 64'd9, 64'd2, 16'h0, 0, 0, 0, 0, 1, 0);
    run_op("R11 cmp zero", 4'd1, 64'd9, 64'd9, 16'h0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_latency;
    logic [W-1:0] held;
    held = result;
    @(negedge clk);
    in_valid = 1'b0; opa = 64'h1234; opb = 64'h5678; op = 4'd0;
    @(posedge clk); #2;
    chk("R2 idle valid", {63'h0, out_valid}, 64'd0);
    chk("R2 idle hold", result, held);
    chk("R2 idle strobes", {62'h0, ov_wr, cmp_wr}, 64'd0);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; op = '0; ra_is_zero = 1'b0; opa = '0; opb = '0;
    imm = '0; nia = '0; ca_in = 1'b0; ov_in = 1'b0; alt_mode = 1'b0;
    ov_en = 1'b0; cmp_en = 1'b0;
    t_reset();
    t_basic();
    t_extended();
    t_immediate();
    t_rzero();
    t_pcis();
    t_altcarry();
    t_overflow();
    t_enables();
    t_latency();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule